// File: doc/BRIEF.md
# Dual 8-bit Multimode Timer

This block holds two 8-bit up counters. Each counter has its own compare register. A shared 2-bit mode register picks one of four arrangements of the pair:

- two independent interval timers;
- one 16-bit interval timer built from both counters;
- a programmable pulse generator whose output toggles at two compare points;
- an 8-bit pulse-width modulator on the first counter.

A single timer flip-flop drives the output pin. It responds to counter events and to a software control port. Count enables come from an external prescaler, one per timer. Pin multiplexing lies outside the block.

The mode register is the state of the block. Its states are DUAL (code 00), CASC (code 01), PPG (code 10) and PWM (code 11). There is one kind of transition, a mode write. A mode write moves from any state to the written state on the next clock edge. Apart from reset, which enters DUAL, there is no other transition. A double-buffer bit is written together with the mode. While that bit is set in PPG or PWM, writes to compare register 0 go to a buffer. The buffer is copied into compare register 0 at the end of each period.

Top module: `tmr8_pair`

## Requirements
- R1: After reset, irq0, irq1 and tff_out are 0, the mode is DUAL, both counters are zero and the double-buffer bit is clear.
- R2: In DUAL, each timer counts one step for every cycle with its run bit and count enable high. On the step that would bring a counter to its compare value, the counter clears to zero instead and that timer's interrupt pulses for one cycle. The period is therefore the compare value in steps, with 0 meaning 256.
- R3: In DUAL with t1_src_match=1, timer 1 counts one step for each timer 0 match instead of on tick1. In DUAL and CASC, tff_out inverts at each timer 1 match.
- R4: A flip-flop control write acts on tff_out at the next edge, by code: 00 invert, 01 set, 10 clear, 11 no action. A write with code 00, 01 or 10 overrides any counter event in the same cycle. ffc_rdata always reads 2'b11.
- R5: In CASC, the counters form one 16-bit counter, with timer 1 as the high byte. It counts on tick0 and compares against {compare 1, compare 0}. On a match both halves clear. Only irq1 pulses; irq0 stays 0.
- R6: In PPG, counter 0 counts on tick0. tff_out inverts when the count reaches compare 0, and inverts again when it reaches compare 1. At the compare 1 match the counter also clears and irq0 pulses. Compare 0 must be smaller than compare 1.
- R7: In PWM, counter 0 runs freely through 256 steps. tff_out is cleared when the count reaches compare 0. It is set, and irq0 pulses, when the counter overflows from 255 to 0. When both happen on one step, the set wins. In PPG and PWM, timer 1 is held at zero and irq1 stays 0.
- R8: With the double-buffer bit set, in PPG or PWM, compare 0 writes go to a buffer. The buffer loads into compare 0 at the compare 1 match (PPG) or at overflow (PWM). In all other cases a compare 0 write takes effect at once.
- R9: A run bit at 0 holds its counter at zero from the next edge. When counting resumes, it starts from zero.
- R10: A counter does not move in a cycle whose count enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run0 | input | 1 | Run enable, timer 0 |
| run1 | input | 1 | Run enable, timer 1 |
| tick0 | input | 1 | Count enable from the prescaler, timer 0 |
| tick1 | input | 1 | Count enable from the prescaler, timer 1 |
| t1_src_match | input | 1 | In DUAL, timer 1 counts on timer 0 matches |
| cmp0_we | input | 1 | Compare 0 write strobe |
| cmp0_wdata | input | 8 | Compare 0 write value |
| cmp1_we | input | 1 | Compare 1 write strobe |
| cmp1_wdata | input | 8 | Compare 1 write value |
| mode_we | input | 1 | Mode write strobe |
| mode_wdata | input | 2 | Mode code: 00 DUAL, 01 CASC, 10 PPG, 11 PWM |
| dbuf_wdata | input | 1 | Double-buffer enable, written with the mode |
| ffc_we | input | 1 | Flip-flop control write strobe |
| ffc_wdata | input | 2 | Flip-flop control code |
| ffc_rdata | output | 2 | Flip-flop control readback, always 11 |
| irq0 | output | 1 | Timer 0 interrupt pulse |
| irq1 | output | 1 | Timer 1 interrupt pulse |
| tff_out | output | 1 | Timer flip-flop output |

## Verification
Counters, interrupts and the flip-flop are all registered on the edge of the step that causes them. Each step's result is therefore visible in the cycle after that edge: one cycle of latency for matches, overflows, buffer loads and control writes. The bench drives inputs on the falling edge and samples every output at the falling edge after each rising edge, so step N of a run is read in sample N. Pulse counts and the final flip-flop level are compared with values worked out from the step arithmetic in the requirements. The directed tests look at the exact sample index of single events, such as a restart after the run bit drops, a gated step, a buffered compare reload, and a control write that collides with a match.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    typedef enum logic [1:0] {
        MODE_DUAL = 2'b00,
        MODE_CASC = 2'b01,
        MODE_PPG  = 2'b10,
        MODE_PWM  = 2'b11
    } tmode_e;

    typedef enum logic [1:0] {
        FF_INV  = 2'b00,
        FF_SET  = 2'b01,
        FF_CLR  = 2'b10,
        FF_KEEP = 2'b11
    } ffop_e;

    typedef struct packed {
        logic toggle;
        logic set;
        logic clr;
    } ffev_t;

    function automatic logic is_wave_mode(tmode_e m);
        return (m == MODE_PPG) || (m == MODE_PWM);
    endfunction

endpackage

// File: rtl/tmr8_cfg.sv
module tmr8_cfg
    import tmr8_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_we,
    input  logic [1:0]    mode_wdata,
    input  logic          dbuf_wdata,
    input  logic          cmp0_we,
    input  logic [CW-1:0] cmp0_wdata,
    input  logic          cmp1_we,
    input  logic [CW-1:0] cmp1_wdata,
    input  logic          reload_i,
    output tmode_e        mode_o,
    output logic [CW-1:0] cmp0_o,
    output logic [CW-1:0] cmp1_o
);

    tmode_e        mode_q, mode_d;
    logic          dbuf_q;
    logic [CW-1:0] cmp0_q, cmp1_q, buf0_q;
    logic          buffered;

    // mode state: reset enters DUAL, a mode write jumps to the written state
    always_comb begin
        mode_d = mode_q;
        if (mode_we) begin
            unique case (mode_wdata)
                2'b00: mode_d = MODE_DUAL;
                2'b01: mode_d = MODE_CASC;
                2'b10: mode_d = MODE_PPG;
                2'b11: mode_d = MODE_PWM;
                default: mode_d = mode_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_DUAL;
        else        mode_q <= mode_d;
    end

    assign buffered = dbuf_q && is_wave_mode(mode_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dbuf_q <= 1'b0;
            cmp0_q <= '0;
            cmp1_q <= '0;
            buf0_q <= '0;
        end else begin
            if (mode_we) dbuf_q <= dbuf_wdata;
            if (cmp1_we) cmp1_q <= cmp1_wdata;
            if (cmp0_we) buf0_q <= cmp0_wdata;
            if (reload_i && dbuf_q)         cmp0_q <= buf0_q;
            else if (cmp0_we && !buffered)  cmp0_q <= cmp0_wdata;
        end
    end

    assign mode_o = mode_q;
    assign cmp0_o = cmp0_q;
    assign cmp1_o = cmp1_q;

    AST_BUF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_i && dbuf_q) |=> (cmp0_q == $past(buf0_q))); // R8
    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (buffered && !reload_i) |=> $stable(cmp0_q)); // R8

endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
    import tmr8_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tmode_e        mode_i,
    input  logic          run0_i,
    input  logic          run1_i,
    input  logic          tick0_i,
    input  logic          tick1_i,
    input  logic          t1_src_i,
    input  logic [CW-1:0] cmp0_i,
    input  logic [CW-1:0] cmp1_i,
    output logic          irq0_o,
    output logic          irq1_o,
    output logic          reload_o,
    output ffev_t         ev_o
);

    localparam int            CW2 = 2 * CW;
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0]  cnt0_q, cnt1_q, cnt0_d, cnt1_d;
    logic [CW-1:0]  c0_inc, c1_inc;
    logic [CW2-1:0] cat_next;
    logic           step0, step1, carry;
    logic           irq0_ev, irq1_ev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt0_q <= '0;
            cnt1_q <= '0;
            irq0_o <= 1'b0;
            irq1_o <= 1'b0;
        end else begin
            cnt0_q <= cnt0_d;
            cnt1_q <= cnt1_d;
            irq0_o <= irq0_ev;
            irq1_o <= irq1_ev;
        end
    end

    always_comb begin
        step0    = run0_i && tick0_i;
        c0_inc   = cnt0_q + ONE;
        c1_inc   = cnt1_q + ONE;
        cnt0_d   = run0_i ? cnt0_q : '0;
        cnt1_d   = run1_i ? cnt1_q : '0;
        irq0_ev  = 1'b0;
        irq1_ev  = 1'b0;
        reload_o = 1'b0;
        ev_o     = '0;
        step1    = 1'b0;
        carry    = 1'b0;
        cat_next = '0;
        unique case (mode_i)
            MODE_DUAL: begin
                if (step0) begin
                    if (c0_inc == cmp0_i) begin
                        cnt0_d  = '0;
                        irq0_ev = 1'b1;
                    end else begin
                        cnt0_d = c0_inc;
                    end
                end
                step1 = run1_i && (t1_src_i ? irq0_ev : tick1_i);
                if (step1) begin
                    if (c1_inc == cmp1_i) begin
                        cnt1_d      = '0;
                        irq1_ev     = 1'b1;
                        ev_o.toggle = 1'b1;
                    end else begin
                        cnt1_d = c1_inc;
                    end
                end
            end
            MODE_CASC: begin
                carry = step0 && (cnt0_q == '1);
                if (step0) cnt0_d = c0_inc;
                if (run1_i && carry) cnt1_d = c1_inc;
                cat_next = {cnt1_d, cnt0_d};
                if (step0 && (cat_next == {cmp1_i, cmp0_i})) begin
                    cnt0_d      = '0;
                    cnt1_d      = '0;
                    irq1_ev     = 1'b1;
                    ev_o.toggle = 1'b1;
                end
            end
            MODE_PPG: begin
                cnt1_d = '0;
                if (step0) begin
                    if (c0_inc == cmp1_i) begin
                        cnt0_d      = '0;
                        irq0_ev     = 1'b1;
                        reload_o    = 1'b1;
                        ev_o.toggle = 1'b1;
                    end else begin
                        cnt0_d = c0_inc;
                        if (c0_inc == cmp0_i) ev_o.toggle = 1'b1;
                    end
                end
            end
            MODE_PWM: begin
                cnt1_d = '0;
                if (step0) begin
                    cnt0_d = c0_inc;
                    if (cnt0_q == '1) begin
                        irq0_ev  = 1'b1;
                        reload_o = 1'b1;
                        ev_o.set = 1'b1;
                    end else if (c0_inc == cmp0_i) begin
                        ev_o.clr = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    AST_HALT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run0_i |=> (cnt0_q == '0)); // R9
    AST_DUAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(mode_i) == MODE_DUAL) && irq0_o) |-> (cnt0_q == '0)); // R2
    AST_CASC_IRQ0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_i) == MODE_CASC) |-> !irq0_o); // R5
    AST_WAVE_IRQ1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        is_wave_mode($past(mode_i)) |-> (!irq1_o && (cnt1_q == '0))); // R7
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run0_i && !tick0_i) |=> $stable(cnt0_q)); // R10

endmodule

// File: rtl/tmr8_flop.sv
module tmr8_flop
    import tmr8_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ffc_we,
    input  logic [1:0] ffc_wdata,
    input  ffev_t      ev_i,
    output logic       q_o
);

    ffop_e op;
    logic  q_d;

    assign op = ffop_e'(ffc_wdata);

    always_comb begin
        q_d = q_o;
        if (ffc_we && (op != FF_KEEP)) begin
            unique case (op)
                FF_INV:  q_d = ~q_o;
                FF_SET:  q_d = 1'b1;
                FF_CLR:  q_d = 1'b0;
                default: q_d = q_o;
            endcase
        end else if (ev_i.set) begin
            q_d = 1'b1;
        end else if (ev_i.clr) begin
            q_d = 1'b0;
        end else if (ev_i.toggle) begin
            q_d = ~q_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= 1'b0;
        else        q_o <= q_d;
    end

    AST_FF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ffc_we && (ffc_wdata == 2'b01)) |=> q_o); // R4
    AST_FF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (ffc_we && (ffc_wdata == 2'b10)) |=> !q_o); // R4

endmodule

// File: rtl/tmr8_pair.sv
module tmr8_pair
    import tmr8_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run0,
    input  logic          run1,
    input  logic          tick0,
    input  logic          tick1,
    input  logic          t1_src_match,
    input  logic          cmp0_we,
    input  logic [CW-1:0] cmp0_wdata,
    input  logic          cmp1_we,
    input  logic [CW-1:0] cmp1_wdata,
    input  logic          mode_we,
    input  logic [1:0]    mode_wdata,
    input  logic          dbuf_wdata,
    input  logic          ffc_we,
    input  logic [1:0]    ffc_wdata,
    output logic [1:0]    ffc_rdata,
    output logic          irq0,
    output logic          irq1,
    output logic          tff_out
);

    tmode_e        mode;
    logic [CW-1:0] cmp0, cmp1;
    logic          reload;
    ffev_t         ev;

    tmr8_cfg #(.CW(CW)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .dbuf_wdata (dbuf_wdata),
        .cmp0_we    (cmp0_we),
        .cmp0_wdata (cmp0_wdata),
        .cmp1_we    (cmp1_we),
        .cmp1_wdata (cmp1_wdata),
        .reload_i   (reload),
        .mode_o     (mode),
        .cmp0_o     (cmp0),
        .cmp1_o     (cmp1)
    );

    tmr8_core #(.CW(CW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode),
        .run0_i   (run0),
        .run1_i   (run1),
        .tick0_i  (tick0),
        .tick1_i  (tick1),
        .t1_src_i (t1_src_match),
        .cmp0_i   (cmp0),
        .cmp1_i   (cmp1),
        .irq0_o   (irq0),
        .irq1_o   (irq1),
        .reload_o (reload),
        .ev_o     (ev)
    );

    tmr8_flop u_flop (
        .clk       (clk),
        .rst_n     (rst_n),
        .ffc_we    (ffc_we),
        .ffc_wdata (ffc_wdata),
        .ev_i      (ev),
        .q_o       (tff_out)
    );

    assign ffc_rdata = 2'b11;

    AST_PULSE_SINGLE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq0 && irq1) |-> ($past(mode) == MODE_DUAL)); // R5

endmodule

// File: tb/tb_tmr8_pair.sv
module tb_tmr8_pair;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run0 = 0, run1 = 0, tick0 = 1, tick1 = 1, t1_src_match = 0;
    logic       cmp0_we = 0, cmp1_we = 0, mode_we = 0, dbuf_wdata = 0, ffc_we = 0;
    logic [7:0] cmp0_wdata = 0, cmp1_wdata = 0;
    logic [1:0] mode_wdata = 0, ffc_wdata = 0;
    logic [1:0] ffc_rdata;
    logic       irq0, irq1, tff_out;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    tmr8_pair dut (
        .clk(clk), .rst_n(rst_n), .run0(run0), .run1(run1), .tick0(tick0), .tick1(tick1),
        .t1_src_match(t1_src_match), .cmp0_we(cmp0_we), .cmp0_wdata(cmp0_wdata),
        .cmp1_we(cmp1_we), .cmp1_wdata(cmp1_wdata), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .dbuf_wdata(dbuf_wdata), .ffc_we(ffc_we), .ffc_wdata(ffc_wdata), .ffc_rdata(ffc_rdata),
        .irq0(irq0), .irq1(irq1), .tff_out(tff_out)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [7:0]  c0;
        logic [7:0]  c1;
        logic        src;
        logic [11:0] n;
        logic [7:0]  e0;
        logic [7:0]  e1;
        logic        eff;
    } vec_t;

    // mode, cmp0, cmp1, t1 source, steps, expected irq0 pulses, irq1 pulses, final tff
    localparam vec_t VECS [7] = '{
        '{2'b00, 8'd5,    8'd3,  1'b0, 12'd20,  8'd4,  8'd6,  1'b0},
        '{2'b00, 8'd4,    8'd3,  1'b1, 12'd40,  8'd10, 8'd3,  1'b1},
        '{2'b00, 8'd0,    8'd7,  1'b0, 12'd300, 8'd1,  8'd42, 1'b0},
        '{2'b01, 8'h04,   8'h01, 1'b0, 12'd300, 8'd0,  8'd1,  1'b1},
        '{2'b10, 8'd2,    8'd5,  1'b0, 12'd18,  8'd3,  8'd0,  1'b1},
        '{2'b11, 8'h40,   8'd0,  1'b0, 12'd330, 8'd1,  8'd0,  1'b0},
        '{2'b11, 8'h00,   8'd0,  1'b0, 12'd600, 8'd2,  8'd0,  1'b1}
    };

    function automatic string vtag(int v);
        case (v)
            0: return "R2";
            1: return "R3";
            2: return "R2";
            3: return "R5";
            4: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic tick_sample();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_cycle();
        run0 = 0; run1 = 0;
        tick_sample();
    endtask

    task automatic configure(logic [1:0] m, logic db, logic [7:0] c0, logic [7:0] c1);
        mode_we = 1; mode_wdata = m; dbuf_wdata = db;
        cmp0_we = 1; cmp0_wdata = c0;
        cmp1_we = 1; cmp1_wdata = c1;
        ffc_we = 1;  ffc_wdata = 2'b10;
        tick_sample();
        mode_we = 0; cmp0_we = 0; cmp1_we = 0; ffc_we = 0;
    endtask

    task automatic ff_write(logic [1:0] code, logic exp, string what);
        ffc_we = 1; ffc_wdata = code;
        tick_sample();
        ffc_we = 0;
        chk("R4", what, int'(tff_out), int'(exp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R1 watchdog: actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n0, n1, hit_at;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "irq0 after reset", int'(irq0), 0);
        chk("R1", "irq1 after reset", int'(irq1), 0);
        chk("R1", "tff after reset", int'(tff_out), 0);
        chk("R4", "control readback", int'(ffc_rdata), 3);

        // R4 control codes
        ff_write(2'b01, 1'b1, "set");
        ff_write(2'b00, 1'b0, "invert from 1");
        ff_write(2'b11, 1'b0, "no action at 0");
        ff_write(2'b00, 1'b1, "invert from 0");
        ff_write(2'b11, 1'b1, "no action at 1");
        ff_write(2'b10, 1'b0, "clear");

        // vector table: R2 R3 R5 R6 R7
        for (int v = 0; v < 7; v++) begin
            idle_cycle();
            t1_src_match = VECS[v].src;
            tick0 = 1; tick1 = 1;
            configure(VECS[v].mode, 1'b0, VECS[v].c0, VECS[v].c1);
            run0 = 1; run1 = 1;
            n0 = 0; n1 = 0;
            for (int k = 0; k < int'(VECS[v].n); k++) begin
                tick_sample();
                n0 += int'(irq0);
                n1 += int'(irq1);
            end
            run0 = 0; run1 = 0;
            chk(vtag(v), $sformatf("vector %0d irq0 pulses", v), n0, int'(VECS[v].e0));
            chk(vtag(v), $sformatf("vector %0d irq1 pulses", v), n1, int'(VECS[v].e1));
            chk(vtag(v), $sformatf("vector %0d final tff", v), int'(tff_out), int'(VECS[v].eff));
        end
        t1_src_match = 0;

        // R9 restart from zero after run drop
        idle_cycle();
        configure(2'b00, 1'b0, 8'd10, 8'd0);
        run0 = 1;
        repeat (3) tick_sample();
        run0 = 0;
        tick_sample();
        run0 = 1;
        n0 = 0; hit_at = 0;
        for (int k = 1; k <= 10; k++) begin
            tick_sample();
            if (irq0 && k < 10) n0++;
            if (irq0 && k == 10) hit_at = k;
        end
        chk("R9", "early match after restart", n0, 0);
        chk("R9", "match step after restart", hit_at, 10);

        // R10 gated count enable
        idle_cycle();
        configure(2'b00, 1'b0, 8'd3, 8'd0);
        run0 = 1;
        n0 = 0; hit_at = -1;
        for (int k = 0; k < 6; k++) begin
            tick0 = (k % 2 == 0);
            tick_sample();
            if (irq0) begin
                n0++;
                hit_at = k;
            end
        end
        tick0 = 1;
        chk("R10", "pulses with half the enables", n0, 1);
        chk("R10", "cycle of the match", hit_at, 4);

        // R8 buffered compare in PPG
        idle_cycle();
        configure(2'b10, 1'b0, 8'd3, 8'd8);
        mode_we = 1; mode_wdata = 2'b10; dbuf_wdata = 1;
        tick_sample();
        mode_we = 0;
        cmp0_we = 1; cmp0_wdata = 8'd6;
        tick_sample();
        cmp0_we = 0;
        run0 = 1;
        for (int k = 1; k <= 14; k++) begin
            tick_sample();
            if (k == 3)  chk("R8", "old compare used in first period", int'(tff_out), 1);
            if (k == 13) chk("R8", "no toggle before buffered point", int'(tff_out), 0);
            if (k == 14) chk("R8", "toggle at loaded compare", int'(tff_out), 1);
        end
        run0 = 0;

        // R4 write overrides a timer 1 match in the same cycle
        idle_cycle();
        configure(2'b00, 1'b0, 8'd0, 8'd2);
        run1 = 1;
        tick_sample();
        ffc_we = 1; ffc_wdata = 2'b10;
        tick_sample();
        ffc_we = 0;
        chk("R4", "clear beats match toggle", int'(tff_out), 0);
        chk("R3", "timer 1 match pulse", int'(irq1), 1);
        run1 = 0;

        tick_sample();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule